// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for 128 pins. The pins are grouped into four banks of 32. Each pin has a direction bit and an output latch. Software never writes the latch directly. It writes a set register that ORs ones into the latch, or a clear register that removes them. A pin drives its latch value only while its direction bit marks it as an output. On every cycle in which a pin's driven level changes, the pin's change strobe pulses for one cycle, and this happens only for that pin.

The input pins pass through a two-flop synchronizer. The synchronized value is compared with the previous sample to find rising and falling edges. Per-pin enables decide which edges are recorded in a sticky edge status register, which software clears by writing ones. The status feeds three interrupt lines:
- one for bank 0 pin 0,
- one for bank 0 pin 1,
- one for every other pin.

The block also raises a one-cycle wake request when the core is halted and an input pin that appears in a fixed wake mask changes level. Each bank also holds two alternate-function words, which are only stored and read back. Register reads return data one cycle after the request.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every register, the status, the input history and all outputs to zero, so every pin leaves reset as an input.
- R2: Banks 0 to 2 use a packed low map with a 4-byte stride inside each register group: level 0x000, direction 0x00C, set 0x018, clear 0x024, rising enable 0x030, falling enable 0x03C, edge status 0x048. Bank 3 uses the same group offsets plus 0x100. Writes at byte offsets of 0x200 or above are ignored, and reads there return zero.
- R3: Writing the set register ORs the data into the bank's output latch. Writing the clear register clears the latch bits where the data has ones. Both registers read as zero.
- R4: The level register returns the output latch for pins whose direction bit is 1 (output) and the synchronized input for pins whose direction bit is 0.
- R5: A status bit sets on a rising input only when the pin's rising enable is 1 and the pin is an input.
- R6: A status bit sets on a falling input only when the pin's falling enable is 1 and the pin is an input.
- R7: Status bits stay set until software writes a 1 to them in the edge status register. Writing 0 leaves a bit unchanged.
- R8: `irq_pin0` follows status bit 0 of bank 0 and `irq_pin1` follows status bit 1 of bank 0. `irq_other` is the OR of all the remaining status bits of all four banks.
- R9: `wake_req` pulses for one cycle when an input-direction pin toggles while `cpu_halted` is 1 and the pin is in its bank's wake mask. The masks for banks 0 to 3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F.
- R10: `pin_out` is the output latch ANDed with direction. After a direction, set or clear write, `pin_out_chg` is 1 for exactly one cycle on each pin whose driven level changed.
- R11: Two alternate-function words per bank are stored and read back unchanged. Bank b's low word is at 0x054+8b and its high word is at 0x058+8b.
- R12: A read request is answered with `rd_valid` and `rd_data` on the next cycle. A pin change reaches the status register, the level register and `wake_req` on the third clock edge after it appears at `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| pin_in | input | 128 | Asynchronous pin inputs, pin n = bank n/32, bit n%32 |
| cpu_halted | input | 1 | Core halted, qualifies wake requests |
| pin_out | output | 128 | Driven level per pin (latch AND direction) |
| pin_out_chg | output | 128 | One-cycle strobe per pin whose driven level changed |
| irq_pin0 | output | 1 | Interrupt for bank 0 pin 0 status |
| irq_pin1 | output | 1 | Interrupt for bank 0 pin 1 status |
| irq_other | output | 1 | Interrupt for all other status bits |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
The bench aims at the places where the irregular map is easy to get wrong. It writes bank 3 at its high offsets, writes the alternate-function words that sit between the groups, and writes beyond 0x200. A decoder that wraps or aliases would corrupt a low-bank register or return nonzero data there. It checks that a direction write alone produces change strobes on exactly the pins whose driven level moved, and that the set and clear registers read as zero. A design that strobed on latch changes, or that returned the latch, would show extra ones. Edges are driven on pins that are disabled, that are configured as outputs, or that lie outside the wake mask. These confirm that status, interrupts and wake stay quiet in those cases, and that a partial write-one-to-clear leaves the other sticky bits and `irq_other` in place.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NBANK = 4;
    localparam int BW    = 32;
    localparam int NPIN  = NBANK * BW;
    localparam int AW    = 12;
    localparam int NALT  = 2 * NBANK;
    localparam int BANK_W = $clog2(NBANK);

    typedef enum logic [3:0] {
        K_NONE, K_LEVEL, K_DIR, K_SET, K_CLR, K_RISE, K_FALL, K_EDGE, K_ALT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [BANK_W-1:0] bank;
        logic              alt_hi;
    } reg_sel_t;

    // group number (offset / 0x0C inside a bank's packed map) to register kind
    function automatic reg_kind_e group_kind(input int g);
        case (g)
            0:       return K_LEVEL;
            1:       return K_DIR;
            2:       return K_SET;
            3:       return K_CLR;
            4:       return K_RISE;
            5:       return K_FALL;
            6:       return K_EDGE;
            default: return K_NONE;
        endcase
    endfunction

    // byte offset to register selection; K_NONE for unmapped or out of range
    function automatic reg_sel_t decode(input logic [AW-1:0] a);
        reg_sel_t s;
        int       w;
        s = '{kind: K_NONE, bank: '0, alt_hi: 1'b0};
        w = int'(a[7:2]);
        if (a[1:0] == 2'b00 && a[AW-1:9] == '0) begin
            if (a[8]) begin
                if (w % 3 == 0 && w <= 18) begin
                    s.kind = group_kind(w / 3);
                    s.bank = BANK_W'(3);
                end
            end else if (w <= 20) begin
                s.kind = group_kind(w / 3);
                s.bank = BANK_W'(w % 3);
            end else if (w <= 20 + NALT) begin
                s.kind   = K_ALT;
                s.bank   = BANK_W'((w - 21) / 2);
                s.alt_hi = ((w - 21) % 2) == 1;
            end
        end
        return s;
    endfunction

    function automatic logic [BW-1:0] wake_mask(input int b);
        case (b)
            0:       return 32'h8003_FE1B;
            1:       return 32'h0020_01FC;
            2:       return 32'hEC08_0000;
            3:       return 32'h0012_007F;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
    parameter int          BW        = 32,
    parameter logic [31:0] WAKE_MASK = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] sample,
    input  logic [BW-1:0] dir_i,
    input  logic [BW-1:0] rise_en,
    input  logic [BW-1:0] fall_en,
    input  logic          clr_we,
    input  logic [BW-1:0] clr_mask,
    input  logic          halted,
    output logic [BW-1:0] level_q,
    output logic [BW-1:0] status_q,
    output logic          wake_q
);
    logic [BW-1:0] hit;
    logic [BW-1:0] toggled;
    logic [BW-1:0] wipe;

    always_comb begin
        toggled = (sample ^ level_q) & ~dir_i;
        hit     = ~dir_i & ((rise_en & sample & ~level_q) |
                            (fall_en & ~sample & level_q));
        wipe    = clr_we ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q  <= '0;
            status_q <= '0;
            wake_q   <= 1'b0;
        end else begin
            level_q  <= sample;
            // a new edge in the clearing cycle wins so it is not lost
            status_q <= (status_q & ~wipe) | hit;
            wake_q   <= halted && |(toggled & WAKE_MASK[BW-1:0]);
        end
    end

    // R7: without a clear write no status bit is ever lost
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R5 / R6: newly set status bits belong to input-direction pins only
    assert_input_only_R5: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~$past(status_q) & $past(dir_i)) == '0));

    // R9: wake never fires while the core was running
    assert_wake_halted_R9: assert property (@(posedge clk) disable iff (rst)
        !halted |=> !wake_q);
endmodule

// File: rtl/gpio_drive_track.sv
module gpio_drive_track #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] drive_i,
    output logic [W-1:0] chg_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= drive_i;
    end

    assign chg_o = drive_i ^ prev_q;

    // R10: a driven level that held across the edge produces no strobe
    assert_strobe_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        $stable(drive_i) |-> (chg_o == '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [BW-1:0]   req_wdata,
    output logic            rd_valid,
    output logic [BW-1:0]   rd_data,
    input  logic [NPIN-1:0] pin_in,
    input  logic            cpu_halted,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_out_chg,
    output logic            irq_pin0,
    output logic            irq_pin1,
    output logic            irq_other,
    output logic            wake_req
);
    reg_sel_t        sel;
    logic            wr_go;
    logic [BW-1:0]   dir_q  [NBANK];
    logic [BW-1:0]   olev_q [NBANK];
    logic [BW-1:0]   rise_q [NBANK];
    logic [BW-1:0]   fall_q [NBANK];
    logic [BW-1:0]   alt_q  [NALT];
    logic [BW-1:0]   lvl_w  [NBANK];
    logic [BW-1:0]   stat_w [NBANK];
    logic [NBANK-1:0] wake_w;
    logic [NPIN-1:0] pin_s;
    logic [BW-1:0]   rd_next;

    assign sel   = decode(req_addr);
    assign wr_go = req_valid && req_write;

    gpio_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBANK; b++) begin
                dir_q[b]  <= '0;
                olev_q[b] <= '0;
                rise_q[b] <= '0;
                fall_q[b] <= '0;
            end
            for (int k = 0; k < NALT; k++) alt_q[k] <= '0;
        end else if (wr_go) begin
            case (sel.kind)
                K_DIR:  dir_q[sel.bank]  <= req_wdata;
                K_SET:  olev_q[sel.bank] <= olev_q[sel.bank] | req_wdata;
                K_CLR:  olev_q[sel.bank] <= olev_q[sel.bank] & ~req_wdata;
                K_RISE: rise_q[sel.bank] <= req_wdata;
                K_FALL: fall_q[sel.bank] <= req_wdata;
                K_ALT:  alt_q[{sel.bank, sel.alt_hi}] <= req_wdata;
                default: ;
            endcase
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        gpio_edge_bank #(.BW(BW), .WAKE_MASK(wake_mask(b))) u_edge (
            .clk      (clk),
            .rst      (rst),
            .sample   (pin_s[b*BW +: BW]),
            .dir_i    (dir_q[b]),
            .rise_en  (rise_q[b]),
            .fall_en  (fall_q[b]),
            .clr_we   (wr_go && sel.kind == K_EDGE && sel.bank == BANK_W'(b)),
            .clr_mask (req_wdata),
            .halted   (cpu_halted),
            .level_q  (lvl_w[b]),
            .status_q (stat_w[b]),
            .wake_q   (wake_w[b])
        );
        assign pin_out[b*BW +: BW] = olev_q[b] & dir_q[b];
    end

    gpio_drive_track #(.W(NPIN)) u_track (
        .clk(clk), .rst(rst), .drive_i(pin_out), .chg_o(pin_out_chg)
    );

    always_comb begin
        case (sel.kind)
            K_LEVEL: rd_next = (olev_q[sel.bank] & dir_q[sel.bank]) |
                               (lvl_w[sel.bank] & ~dir_q[sel.bank]);
            K_DIR:   rd_next = dir_q[sel.bank];
            K_RISE:  rd_next = rise_q[sel.bank];
            K_FALL:  rd_next = fall_q[sel.bank];
            K_EDGE:  rd_next = stat_w[sel.bank];
            K_ALT:   rd_next = alt_q[{sel.bank, sel.alt_hi}];
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req_valid && !req_write;
            rd_data  <= (req_valid && !req_write) ? rd_next : '0;
        end
    end

    always_comb begin
        irq_pin0  = stat_w[0][0];
        irq_pin1  = stat_w[0][1];
        irq_other = |stat_w[0][BW-1:2];
        for (int b = 1; b < NBANK; b++) irq_other = irq_other | (|stat_w[b]);
        wake_req  = |wake_w;
    end

    // R12: every read request is answered on the next cycle
    assert_rd_latency_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rd_valid);

    // R2: reads beyond the decoded window return zero
    assert_oob_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr >= AW'(12'h200)) |=> (rd_data == '0));

    // R3: set/clear registers are write-only and read as zero
    assert_setclr_rd_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && (sel.kind == K_SET || sel.kind == K_CLR))
            |=> (rd_data == '0));
endmodule

// File: tb/sim_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctrl;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [11:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         rd_valid;
    logic [31:0]  rd_data;
    logic [127:0] pin_in = '0;
    logic         cpu_halted = 1'b0;
    logic [127:0] pin_out;
    logic [127:0] pin_out_chg;
    logic         irq_pin0, irq_pin1, irq_other, wake_req;

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    gpio_bank_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .pin_in(pin_in), .cpu_halted(cpu_halted),
        .pin_out(pin_out), .pin_out_chg(pin_out_chg), .irq_pin0(irq_pin0),
        .irq_pin1(irq_pin1), .irq_other(irq_other), .wake_req(wake_req)
    );

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // driver side of the scoreboard: push the expected word, issue the read
    task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor side: compare each returned word against the queue head
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL R12 unexpected read data actual=%h expected=none", rd_data);
            end else begin
                chk(tag_q.pop_front(), {96'b0, rd_data}, {96'b0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #500000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        settle(3);
        rst = 1'b0;
        settle(1);
        // R1 reset state
        chk("R1 pin_out", pin_out, '0);
        chk("R1 irqs", {125'b0, irq_pin0, irq_pin1, irq_other}, '0);
        chk("R1 wake", {127'b0, wake_req}, '0);
        rd(12'h000, 32'h0, "R1 level bank0");
        rd(12'h10C, 32'h0, "R1 dir bank3");

        // R2 / R11 map corners
        wr(12'h06C, 32'hA5A5_1234);
        wr(12'h070, 32'h5A5A_8765);
        wr(12'h054, 32'h0000_00C3);
        rd(12'h06C, 32'hA5A5_1234, "R11 alt low bank3");
        rd(12'h070, 32'h5A5A_8765, "R11 alt high bank3");
        rd(12'h054, 32'h0000_00C3, "R11 alt low bank0");
        wr(12'h200, 32'hFFFF_FFFF);
        wr(12'h300, 32'hFFFF_FFFF);
        rd(12'h200, 32'h0, "R2 out of range read");
        rd(12'h000, 32'h0, "R2 ignored write bank0 level");
        wr(12'h10C, 32'h0000_00F0);
        rd(12'h10C, 32'h0000_00F0, "R2 bank3 dir high offset");
        rd(12'h014, 32'h0, "R2 bank2 dir untouched");
        rd(12'h00C, 32'h0, "R2 bank0 dir untouched");

        // R3 / R10 outputs
        wr(12'h00C, 32'h0000_00FF);
        chk("R10 dir write no drive change", pin_out_chg, '0);
        wr(12'h018, 32'h0000_0F0F);
        chk("R10 set drives", pin_out[31:0], 128'h0F);
        chk("R10 set strobe", pin_out_chg, 128'h0F);
        settle(1);
        chk("R10 strobe one cycle", pin_out_chg, '0);
        rd(12'h018, 32'h0, "R3 set reads zero");
        wr(12'h024, 32'h0000_0003);
        chk("R3 clear drives", pin_out[31:0], 128'h0C);
        chk("R10 clear strobe", pin_out_chg, 128'h03);
        rd(12'h024, 32'h0, "R3 clear reads zero");
        pin_in[31:0] = 32'hAAAA_0000;
        settle(4);
        rd(12'h000, 32'hAAAA_000C, "R4 level mix");
        wr(12'h00C, 32'h0000_0F00);
        chk("R10 dir change strobe", pin_out_chg, 128'h0F0C);
        chk("R10 dir change drive", pin_out, 128'h0F00);
        wr(12'h00C, 32'h0);
        chk("R10 dir to input", pin_out_chg, 128'h0F00);
        wr(12'h118, 32'h0000_00FF);
        chk("R10 bank3 drive", pin_out, {32'h0000_00F0, 96'b0});
        pin_in[31:0] = '0;
        settle(4);

        // R5 / R6 / R7 / R8 edges
        wr(12'h030, 32'h0000_0007);
        wr(12'h03C, 32'h0000_0004);
        pin_in[2:0] = 3'b111;
        settle(3);
        chk("R8 irq split after rise", {125'b0, irq_pin0, irq_pin1, irq_other}, 128'h7);
        rd(12'h048, 32'h0000_0007, "R5 rise status");
        wr(12'h048, 32'h0000_0003);
        chk("R7 partial clear irq", {125'b0, irq_pin0, irq_pin1, irq_other}, 128'h1);
        rd(12'h048, 32'h0000_0004, "R7 other bit kept");
        wr(12'h048, 32'h0000_0004);
        pin_in[2:0] = 3'b000;
        settle(4);
        rd(12'h048, 32'h0000_0004, "R6 fall status");
        wr(12'h048, 32'hFFFF_FFFF);
        wr(12'h00C, 32'h0000_0001);
        pin_in[31:0] = 32'h1;
        settle(4);
        rd(12'h048, 32'h0, "R5 output pin ignored");
        rd(12'h000, 32'h0, "R4 output pin reads latch");
        wr(12'h130, 32'h8000_0000);
        pin_in[127] = 1'b1;
        settle(4);
        chk("R8 bank3 other irq", {127'b0, irq_other}, 128'h1);
        rd(12'h148, 32'h8000_0000, "R2 bank3 status high offset");
        wr(12'h148, 32'h8000_0000);
        chk("R7 clear drops irq", {127'b0, irq_other}, '0);
        rd(12'h148, 32'h0, "R7 bank3 cleared");

        // R9 / R12 wake
        cpu_halted = 1'b1;
        pin_in[34] = 1'b1;
        settle(2);
        chk("R12 wake not early", {127'b0, wake_req}, '0);
        settle(1);
        chk("R9 wake pulse", {127'b0, wake_req}, 128'h1);
        settle(1);
        chk("R9 wake one cycle", {127'b0, wake_req}, '0);
        pin_in[32] = 1'b1;
        settle(3);
        chk("R9 unmasked pin no wake", {127'b0, wake_req}, '0);
        cpu_halted = 1'b0;
        pin_in[34] = 1'b0;
        settle(3);
        chk("R9 running no wake", {127'b0, wake_req}, '0);

        settle(3);
        if (exp_q.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL R12 missing reads actual=%0d expected=0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule